// File: doc/BRIEF.md
# DMA Pacing Rate Generator

This block produces the timing strobe that paces memory-to-converter transfers. A reference strobe, one system-clock cycle wide and nominally at 1 MHz, is thinned by a fixed prescaler to form the count clock of a first 16-bit down-counter. That first stage runs as a periodic rate generator, and its output is driven to an external pin. Each falling edge of that output clocks a second 16-bit down-counter running in software-strobe mode, and the second counter's output is the pacing signal.

Software programs both stages through a small byte-wide write port. A shared control port selects the stage and its mode. Per-stage data ports take the 16-bit count as two writes, low byte first. Bit 6 of the converter control register gates the whole chain. Everything runs in the system clock domain, so the prescaler output and the stage-0 falling edge act as clock enables rather than as clocks.

Top module: `pace_rate_gen`

## Requirements
- R1: After reset both `tmr0_o` and `pace_o` are high, and they stay high until the chain is enabled and programmed.
- R2: Stage 0 advances once for every PRESCALE reference strobes (default 8). The low pulse of `tmr0_o` in rate mode lasts exactly one stage-0 count clock, which is PRESCALE strobes.
- R3: A write to offset 11 is a control word. Bits 7:6 select the stage (0 = stage 0, 1 = stage 1; values 2 and 3 are ignored and leave both outputs unchanged). Bits 3:1 select the mode: x10 is rate mode and 100 is strobe mode. A control word forces the selected output high, resets that stage's byte pointer to the low byte, and stops the stage until both count bytes are written.
- R4: The count of stage 0 is written at offset 8 and the count of stage 1 at offset 9. In each case the low byte is written first, then the high byte.
- R5: In rate mode the output falls every N count clocks, where N is the loaded count and a count of 0 means 65536.
- R6: In rate mode, a count written while the stage runs does not alter the period in progress. It takes effect at the next reload.
- R7: Stage 1 counts falling edges of `tmr0_o`. In strobe mode `pace_o` falls one system cycle after the N1-th stage-0 falling edge that follows the one that loaded it. It stays low for one stage-1 clock and does not reload afterwards.
- R8: A write to offset 0 sets the chain enable from data bit 6. While the enable is clear, both outputs are high and nothing counts. Setting the enable again restarts both stages from their full counts, so the first `tmr0_o` fall comes PRESCALE×N0 strobes after the enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference strobe, one cycle per reference period |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | ADDR_W | Host write offset |
| wr_data_i | input | 8 | Host write data |
| tmr0_o | output | 1 | Stage-0 output, driven to the external pin |
| pace_o | output | 1 | Stage-1 output; an active-low pacing strobe |

## Verification
The bench builds the block with its defaults: a prescale of 8 and 16-bit counters. It drives the reference strobe on every system cycle, so one stage-0 count clock equals eight system cycles and every expected edge time is an exact multiple of that. This keeps the multi-byte count of 261, the cascade delay into the pacing strobe, the mid-period reload and the disable/restart timing all within a few thousand cycles. A count of 0 and the stage-1 wrap after 65536 stage-0 periods stay beyond the run length and are covered only by the counter logic itself.

// File: rtl/pace_pkg.sv
package pace_pkg;

  localparam int unsigned OFS_DAC_CTRL = 0;
  localparam int unsigned OFS_CNT0     = 8;
  localparam int unsigned OFS_TCTRL    = 11;
  localparam int unsigned NUM_STAGES   = 2;
  localparam int unsigned EN_BIT       = 6;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_RATE   = 2'd1,
    MODE_STROBE = 2'd2
  } stage_mode_e;

  function automatic stage_mode_e decode_mode(input logic [2:0] m);
    if (m[1:0] == 2'b10)  return MODE_RATE;
    if (m == 3'b100)      return MODE_STROBE;
    return MODE_IDLE;
  endfunction

endpackage

// File: rtl/pace_prescaler.sv
module pace_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ref_tick_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!en_i)      cnt_q <= '0;
    else if (ref_tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = en_i && ref_tick_i && (cnt_q == LAST);

endmodule

// File: rtl/pace_stage.sv
module pace_stage
  import pace_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        ce_i,
  input  logic        ctrl_wr_i,
  input  stage_mode_e ctrl_mode_i,
  input  logic        data_wr_i,
  input  logic [7:0]  data_i,
  output logic        out_o
);
  localparam int unsigned HI_W = CNT_W - 8;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  stage_mode_e      mode_q;
  logic [CNT_W-1:0] cr_q, cnt_q;
  logic [7:0]       lsb_q;
  logic             hi_next_q, valid_q, load_pend_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_IDLE;
      cr_q        <= '0;
      cnt_q       <= '0;
      lsb_q       <= '0;
      hi_next_q   <= 1'b0;
      valid_q     <= 1'b0;
      load_pend_q <= 1'b1;
      out_q       <= 1'b1;
    end else begin
      if (!en_i) begin
        out_q       <= 1'b1;
        load_pend_q <= 1'b1;
      end else if (ce_i && valid_q) begin
        if (load_pend_q) begin
          cnt_q       <= cr_q;
          load_pend_q <= 1'b0;
          out_q       <= 1'b1;
        end else begin
          unique case (mode_q)
            MODE_RATE: begin
              if (cnt_q == ONE) begin
                cnt_q <= cr_q;           // auto reload
                out_q <= 1'b1;
              end else begin
                cnt_q <= cnt_q - 1'b1;
                out_q <= (cnt_q != TWO);
              end
            end
            MODE_STROBE: begin
              cnt_q <= cnt_q - 1'b1;     // wraps, no reload
              out_q <= (cnt_q != ONE);
            end
            default: ;
          endcase
        end
      end
      // host writes override counting
      if (ctrl_wr_i) begin
        mode_q      <= ctrl_mode_i;
        hi_next_q   <= 1'b0;
        valid_q     <= 1'b0;
        load_pend_q <= 1'b1;
        out_q       <= 1'b1;
      end else if (data_wr_i) begin
        if (!hi_next_q) begin
          lsb_q     <= data_i;
          hi_next_q <= 1'b1;
        end else begin
          cr_q      <= {data_i[HI_W-1:0], lsb_q};
          hi_next_q <= 1'b0;
          valid_q   <= 1'b1;
          if (mode_q == MODE_STROBE) load_pend_q <= 1'b1;
        end
      end
    end
  end

  assign out_o = out_q;

endmodule

// File: rtl/pace_rate_gen.sv
module pace_rate_gen
  import pace_pkg::*;
#(
  parameter int unsigned PRESCALE = 8,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              tmr0_o,
  output logic              pace_o
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_DAC_CTRL);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_TCTRL);

  logic                  en_q;
  logic                  out0_d_q;
  logic [NUM_STAGES-1:0] ce;
  logic [NUM_STAGES-1:0] st_out;
  logic                  ctrl_hit;
  stage_mode_e           ctrl_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           en_q <= 1'b0;
    else if (wr_en_i && wr_addr_i == A_EN) en_q <= wr_data_i[EN_BIT];
  end

  pace_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .ref_tick_i (ref_tick_i),
    .tick_o     (ce[0])
  );

  // stage 1 advances on each falling edge of stage 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out0_d_q <= 1'b1;
    else         out0_d_q <= st_out[0];
  end
  assign ce[1] = out0_d_q & ~st_out[0];

  assign ctrl_hit  = wr_en_i && (wr_addr_i == A_CTRL);
  assign ctrl_mode = decode_mode(wr_data_i[3:1]);

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_CNT0 + i);
    pace_stage #(.CNT_W(CNT_W)) u_stage (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en_q),
      .ce_i        (ce[i]),
      .ctrl_wr_i   (ctrl_hit && (wr_data_i[7:6] == 2'(i))),
      .ctrl_mode_i (ctrl_mode),
      .data_wr_i   (wr_en_i && (wr_addr_i == A_DATA)),
      .data_i      (wr_data_i),
      .out_o       (st_out[i])
    );
  end

  assign tmr0_o = st_out[0];
  assign pace_o = st_out[1];

endmodule

// File: rtl/pace_rate_gen_chk.sv
module pace_rate_gen_chk #(
  parameter int unsigned PRESCALE = 8,
  parameter int unsigned ADDR_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_q,
  input logic [1:0]        ce,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic              tmr0_o,
  input logic              pace_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(11);

  logic ctrl0, ctrl1;
  assign ctrl0 = wr_en_i && wr_addr_i == A_CTRL && wr_data_i[7:6] == 2'd0;
  assign ctrl1 = wr_en_i && wr_addr_i == A_CTRL && wr_data_i[7:6] == 2'd1;

  assert_idle_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (tmr0_o && pace_o));

  assert_ce_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ce));

  assert_pace_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pace_o) |-> ($past(tmr0_o, 2) && !$past(tmr0_o)));

  assert_ctrl_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl0 |=> tmr0_o);

  assert_ctrl1_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl1 |=> pace_o);

  if (PRESCALE > 1) begin : g_hold
    assert_low_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(tmr0_o) && en_q && !ctrl0) |=> !tmr0_o);
  end

endmodule

bind pace_rate_gen pace_rate_gen_chk #(.PRESCALE(PRESCALE), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_q      (en_q),
  .ce        (ce),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .tmr0_o    (tmr0_o),
  .pace_o    (pace_o)
);

// File: tb/pace_rate_gen_test.sv
`timescale 1ns/1ps
module pace_rate_gen_test;
  localparam int PS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tmr0, pace;
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pace_rate_gen #(.PRESCALE(PS), .CNT_W(16), .ADDR_W(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .tmr0_o(tmr0), .pace_o(pace)
  );

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // returns cycle stamp of the write edge
  task automatic host_wr(input logic [3:0] a, input logic [7:0] d, output int t);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    t = cyc;
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    int t;
    host_wr(a, d, t);
  endtask

  task automatic next_edge(input bit which, input bit fall, input int limit, output int t);
    logic prev, cur;
    prev = which ? pace : tmr0;
    t = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      cur = which ? pace : tmr0;
      if (fall ? (prev && !cur) : (!prev && cur)) begin
        t = cyc;
        return;
      end
      prev = cur;
    end
  endtask

  task automatic setup_chain(input logic [15:0] n0, input logic [15:0] n1);
    wr(4'd0, 8'h00);
    wr(4'd11, 8'h34);
    wr(4'd8, n0[7:0]);
    wr(4'd8, n0[15:8]);
    wr(4'd11, 8'h78);
    wr(4'd9, n1[7:0]);
    wr(4'd9, n1[15:8]);
  endtask

  task automatic t_reset;
    check_int("R1 tmr0 after reset", int'(tmr0), 1);
    check_int("R1 pace after reset", int'(pace), 1);
    repeat (50) @(negedge clk);
    check_int("R1 idle outputs", int'(tmr0 & pace), 1);
  endtask

  task automatic t_rate_basic;
    int te, a, b, c;
    setup_chain(16'd3, 16'd2);
    host_wr(4'd0, 8'h40, te);
    next_edge(0, 1, 200, a);
    check_int("R8 first stage0 fall after enable", a - te, PS * 3);
    next_edge(0, 0, 200, b);
    check_int("R2 stage0 low width", b - a, PS);
    next_edge(0, 1, 200, c);
    check_int("R5 stage0 period N0=3", c - a, PS * 3);
  endtask

  task automatic t_pace;
    int te, f0, p, r, q;
    setup_chain(16'd3, 16'd2);
    host_wr(4'd0, 8'h40, te);
    next_edge(0, 1, 200, f0);
    next_edge(1, 1, 400, p);
    check_int("R7 pace fall delay", p - f0, PS * 3 * 2 + 1);
    next_edge(1, 0, 200, r);
    check_int("R7 pace low width", r - p, PS * 3);
    next_edge(1, 1, 500, q);
    check_int("R7 no reload after strobe", q, -1);
  endtask

  task automatic t_bytes;
    int a, b;
    setup_chain(16'h0105, 16'd2);
    wr(4'd0, 8'h40);
    next_edge(0, 1, 4000, a);
    next_edge(0, 1, 4000, b);
    check_int("R4 two-byte count 261 period", b - a, PS * 261);
  endtask

  task automatic t_reload;
    int t1, t2, t3, r;
    setup_chain(16'd3, 16'd2);
    wr(4'd0, 8'h40);
    next_edge(0, 1, 200, t1);
    next_edge(0, 0, 200, r);
    wr(4'd8, 8'd6);
    wr(4'd8, 8'd0);
    next_edge(0, 1, 200, t2);
    check_int("R6 period in progress kept", t2 - t1, PS * 3);
    next_edge(0, 1, 400, t3);
    check_int("R6 new count after reload", t3 - t2, PS * 6);
  endtask

  task automatic t_pointer;
    int te, a, b;
    wr(4'd0, 8'h00);
    wr(4'd11, 8'h34);
    wr(4'd8, 8'h09);
    wr(4'd11, 8'h34);
    wr(4'd8, 8'h04);
    wr(4'd8, 8'h00);
    host_wr(4'd0, 8'h40, te);
    next_edge(0, 1, 400, a);
    check_int("R3 pointer reset by control word", a - te, PS * 4);
    next_edge(0, 1, 400, b);
    check_int("R3 period after pointer reset", b - a, PS * 4);
  endtask

  task automatic t_ignored;
    int a, b, lows;
    next_edge(0, 1, 400, a);
    wr(4'd11, 8'hB4);
    wr(4'd11, 8'hC2);
    next_edge(0, 1, 400, b);
    check_int("R3 stage select 2/3 ignored", b - a, PS * 4);
    lows = 0;
    for (int i = 0; i < PS * 8; i++) begin
      @(negedge clk);
      if (!tmr0) lows++;
    end
    check_int("R3 low time unchanged over two periods", lows, PS * 2);
  endtask

  task automatic t_disable;
    int te, a, lows;
    wr(4'd0, 8'h00);
    lows = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!tmr0 || !pace) lows++;
    end
    check_int("R8 outputs high while disabled", lows, 0);
    host_wr(4'd0, 8'h40, te);
    next_edge(0, 1, 400, a);
    check_int("R8 restart from full count", a - te, PS * 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ref_tick = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate_basic();
    t_pace();
    t_bytes();
    t_reload();
    t_pointer();
    t_ignored();
    t_disable();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected finished", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule